// File: doc/BRIEF.md
# Serial Controller Register Access Unit

This unit is the processor-facing register front end of a two-channel serial communications controller. The host drives a simple strobed bus with a chip select, a read strobe, a write strobe, a channel select and an 8-bit data path. Register addressing is indirect. A write to register 0 of a channel loads that channel's 4-bit register pointer. The next access to that channel goes to the register the pointer names. Once that access ends, the pointer falls back to 0. The unit stores the per-channel write registers and steers writes at address 7 to a hidden alternate register when a sticky steering bit is set. It also multiplexes the read registers onto the data bus, and can optionally expose written values for read-back.

The receive/transmit status byte (read register 0) is captured when a read begins and held until the read strobe or chip select drops, so the host never sees it change mid-cycle. A zero-count pulse from each channel's baud-rate counter is edge-captured into a pending flag. That flag raises the channel's interrupt request while the zero-count enable bit is set.

The access sequencer has three states. `S_IDLE` waits for a strobe: chip select with read taken goes to `S_READ` (read takes priority if both strobes are high); chip select with write goes to `S_WRITE`, performing the write on that edge. `S_READ` and `S_WRITE` return to `S_IDLE` once their strobe or chip select is released, clearing the pointer if the access targeted a non-zero register.

Top module: `scc_regaccess`

## Requirements
- R1: After hardware reset (rst_n low), rdata is 0, irq is 0, every write register and the alternate register read back as 0, and each channel's pointer is 0.
- R2: A write to register 0 loads bits [3:0] of the data into the selected channel's pointer; the next access uses that register, and after any access to a non-zero register the pointer returns to 0.
- R3: Register 15 bit 0 is the steering bit: when 0, writes to address 7 update register 7; when 1 they update the alternate register. The bit stays until register 15 is rewritten, a channel reset, or a hardware reset.
- R4: When alternate register bit 6 is 1, reads of addresses 4, 5, 9, 11 and 14 return the last values written to registers 4, 5, 3, 10 and the alternate register respectively.
- R5: When alternate register bit 6 is 0, reads of addresses 4, 5, 9, 11, 14 and of unimplemented addresses 6, 7, 8 and 10 return the captured read-register-0 byte.
- R6: Address 0 returns the channel's rr0_stat byte as sampled on the edge that starts the read; it stays unchanged until the read ends.
- R7: Addresses 2 and 3 return vec_in and ipend_in on either channel; address 1 returns the selected channel's rr1_stat byte.
- R8: Reads of addresses 12, 13 and 15 return the values last written to registers 12, 13 and 15 of that channel.
- R9: A rising edge on zc_in[ch] sets that channel's pending flag even when disabled; irq[ch] is high while the flag is set and register 15 bit 1 is 1.
- R10: Writing register 0 with bits [6:4] = 3'b010 clears the channel's pending flag.
- R11: Writing register 0 with bits [6:4] = 3'b011 clears all write registers, the alternate register and the pending flag of that channel only.
- R12: rdata is 0 whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| chan_sel | input | CW | Channel select |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, 0 outside a read |
| rr0_stat | input | NCH*DW | Per-channel buffer/external status byte |
| rr1_stat | input | NCH*DW | Per-channel special receive status byte |
| vec_in | input | DW | Shared interrupt vector |
| ipend_in | input | DW | Shared interrupt pending byte |
| zc_in | input | NCH | Per-channel baud counter zero indication |
| irq | output | NCH | Per-channel external/status interrupt request |

## Verification
The hardest state to reach is a read of read-register 0 whose source byte changes while the strobe is still held. The stimulus opens a read, alters rr0_stat on the following cycles and samples the data several cycles later. A second hard case is reaching the alternate register at all. The bench first sets the steering bit through a pointer-then-data write pair, then writes address 7, and finally reads it back via address 14 with the read-back bit enabled. It also sets a pending flag while the enable is off, to show that enabling later exposes it.

// File: rtl/scc_regaccess_pkg.sv
package scc_regaccess_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_READ  = 2'd1,
        S_WRITE = 2'd2
    } acc_state_e;

    localparam int CMD_LSB = 4;
    localparam logic [2:0] CMD_RST_EXT  = 3'b010;
    localparam logic [2:0] CMD_CHAN_RST = 3'b011;

    localparam logic [3:0] A_STAT0 = 4'd0;
    localparam logic [3:0] A_STAT1 = 4'd1;
    localparam logic [3:0] A_VEC   = 4'd2;
    localparam logic [3:0] A_IPEND = 4'd3;
    localparam logic [3:0] A_RB4   = 4'd4;
    localparam logic [3:0] A_RB5   = 4'd5;
    localparam logic [3:0] A_WR7   = 4'd7;
    localparam logic [3:0] A_RB9   = 4'd9;
    localparam logic [3:0] A_WR10  = 4'd10;
    localparam logic [3:0] A_RB11  = 4'd11;
    localparam logic [3:0] A_TC_LO = 4'd12;
    localparam logic [3:0] A_TC_HI = 4'd13;
    localparam logic [3:0] A_RB14  = 4'd14;
    localparam logic [3:0] A_CTRL  = 4'd15;

    localparam int STEER_BIT = 0;
    localparam int ZCIE_BIT  = 1;
    localparam int EXTRD_BIT = 6;
endpackage

// File: rtl/scc_acc_fsm.sv
module scc_acc_fsm
    import scc_regaccess_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 4,
    parameter int CW  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          rd,
    input  logic          wr,
    input  logic [CW-1:0] chan_sel,
    input  logic [AW-1:0] ptr_wdata,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [CW-1:0] acc_ch,
    output logic [AW-1:0] acc_addr,
    output logic          rd_act,
    output logic          snap_en
);
    acc_state_e st_q, st_d;
    logic [NCH-1:0][AW-1:0] ptr_q;
    logic rd_go, wr_go, acc_end;

    always_comb begin
        rd_go   = cs && rd;
        wr_go   = cs && wr && !rd;
        st_d    = st_q;
        acc_end = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                if (rd_go)      st_d = S_READ;
                else if (wr_go) st_d = S_WRITE;
            end
            S_READ: begin
                if (!(cs && rd)) begin
                    st_d    = S_IDLE;
                    acc_end = 1'b1;
                end
            end
            S_WRITE: begin
                if (!(cs && wr)) begin
                    st_d    = S_IDLE;
                    acc_end = 1'b1;
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        wr_en   = (st_q == S_IDLE) && wr_go;
        snap_en = (st_q == S_IDLE) && rd_go;
        rd_act  = (st_q == S_READ);
        wr_addr = ptr_q[chan_sel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_ch   <= '0;
            acc_addr <= '0;
        end else if (snap_en || wr_en) begin
            acc_ch   <= chan_sel;
            acc_addr <= ptr_q[chan_sel];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (wr_en && (ptr_q[chan_sel] == '0)) begin
            ptr_q[chan_sel] <= ptr_wdata;
        end else if (acc_end && (acc_addr != '0)) begin
            ptr_q[acc_ch] <= '0;
        end
    end

    // R2: pointer falls back to 0 after a non-zero access ends
    assert_ptr_home_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_end && (acc_addr != '0)) |=> (ptr_q[acc_ch] == '0));
endmodule

// File: rtl/scc_chan_regs.sv
module scc_chan_regs
    import scc_regaccess_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [AW-1:0]               addr,
    input  logic [DW-1:0]               wdata,
    output logic [(2**AW)-1:0][DW-1:0]  regs_o,
    output logic [DW-1:0]               prime_o,
    output logic                        clr_ext_o,
    output logic                        chan_rst_o
);
    logic       is_ctrl;
    logic       steer;
    logic [2:0] cmd;

    always_comb begin
        cmd        = wdata[CMD_LSB +: 3];
        is_ctrl    = we && (addr == '0);
        clr_ext_o  = is_ctrl && (cmd == CMD_RST_EXT);
        chan_rst_o = is_ctrl && (cmd == CMD_CHAN_RST);
        steer      = regs_o[A_CTRL][STEER_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_o  <= '0;
            prime_o <= '0;
        end else if (chan_rst_o) begin
            regs_o  <= '0;
            prime_o <= '0;
        end else if (we && (addr != '0)) begin
            if ((addr == A_WR7) && steer) prime_o      <= wdata;
            else                          regs_o[addr] <= wdata;
        end
    end

    // R3: steering bit only changes through a register-15 write
    assert_steer_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(we && (addr == A_CTRL)) && !chan_rst_o) |=> $stable(regs_o[A_CTRL][STEER_BIT]));

    // R3: with steering clear, an address-7 write leaves the alternate register alone
    assert_prime_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (addr == A_WR7) && !steer) |=> $stable(prime_o));
endmodule

// File: rtl/scc_zc_irq.sv
module scc_zc_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic zc,
    input  logic en,
    input  logic clr,
    input  logic chan_rst,
    output logic irq,
    output logic pend
);
    logic zc_q;
    logic rise;

    always_comb rise = zc && !zc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zc_q <= 1'b0;
            pend <= 1'b0;
        end else begin
            zc_q <= zc;
            if (rise)                 pend <= 1'b1;
            else if (clr || chan_rst) pend <= 1'b0;
        end
    end

    always_comb irq = pend && en;

    // R9: a rising zero-count edge is always captured
    assert_pend_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> pend);

    // R10: the clear command drops the flag when no new edge arrives
    assert_pend_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !rise) |=> !pend);
endmodule

// File: rtl/scc_regaccess.sv
module scc_regaccess
    import scc_regaccess_pkg::*;
#(
    parameter int DW  = 8,
    parameter int AW  = 4,
    parameter int NCH = 2,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             rd,
    input  logic             wr,
    input  logic [CW-1:0]    chan_sel,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic [NCH*DW-1:0] rr0_stat,
    input  logic [NCH*DW-1:0] rr1_stat,
    input  logic [DW-1:0]    vec_in,
    input  logic [DW-1:0]    ipend_in,
    input  logic [NCH-1:0]   zc_in,
    output logic [NCH-1:0]   irq
);
    localparam int NREG = 2 ** AW;

    logic          wr_en, rd_act, snap_en;
    logic [AW-1:0] wr_addr, acc_addr;
    logic [CW-1:0] acc_ch;
    logic [DW-1:0] snap;
    logic          ext;

    logic [NCH-1:0][NREG-1:0][DW-1:0] wregs;
    logic [NCH-1:0][DW-1:0]           prime;
    logic [NCH-1:0]                   we_ch, clr_ext, chan_rst, pend;

    scc_acc_fsm #(.NCH(NCH), .AW(AW), .CW(CW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs       (cs),
        .rd       (rd),
        .wr       (wr),
        .chan_sel (chan_sel),
        .ptr_wdata(wdata[AW-1:0]),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .acc_ch   (acc_ch),
        .acc_addr (acc_addr),
        .rd_act   (rd_act),
        .snap_en  (snap_en)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign we_ch[g] = wr_en && (chan_sel == CW'(g));

        scc_chan_regs #(.DW(DW), .AW(AW)) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .we        (we_ch[g]),
            .addr      (wr_addr),
            .wdata     (wdata),
            .regs_o    (wregs[g]),
            .prime_o   (prime[g]),
            .clr_ext_o (clr_ext[g]),
            .chan_rst_o(chan_rst[g])
        );

        scc_zc_irq u_zc (
            .clk     (clk),
            .rst_n   (rst_n),
            .zc      (zc_in[g]),
            .en      (wregs[g][A_CTRL][ZCIE_BIT]),
            .clr     (clr_ext[g]),
            .chan_rst(chan_rst[g]),
            .irq     (irq[g]),
            .pend    (pend[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       snap <= '0;
        else if (snap_en) snap <= rr0_stat[chan_sel*DW +: DW];
    end

    always_comb begin
        ext   = prime[acc_ch][EXTRD_BIT];
        rdata = '0;
        if (rd_act) begin
            unique case (acc_addr)
                A_STAT0: rdata = snap;
                A_STAT1: rdata = rr1_stat[acc_ch*DW +: DW];
                A_VEC:   rdata = vec_in;
                A_IPEND: rdata = ipend_in;
                A_RB4, A_RB5:
                         rdata = ext ? wregs[acc_ch][acc_addr] : snap;
                A_RB9:   rdata = ext ? wregs[acc_ch][A_IPEND] : snap;
                A_RB11:  rdata = ext ? wregs[acc_ch][A_WR10] : snap;
                A_RB14:  rdata = ext ? prime[acc_ch] : snap;
                A_TC_LO, A_TC_HI, A_CTRL:
                         rdata = wregs[acc_ch][acc_addr];
                default: rdata = snap;
            endcase
        end
    end

    // R6: the captured status byte holds for the whole read
    assert_snap_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && $past(rd_act)) |-> $stable(snap));

    // R11: a channel reset touches only the addressed channel
    assert_chan_rst_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_rst));
endmodule

// File: tb/tb_scc_regaccess.sv
module tb_scc_regaccess;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [0:0]  chan_sel = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [15:0] rr0_stat = 16'h0000;
    logic [15:0] rr1_stat = 16'h0000;
    logic [7:0]  vec_in = '0, ipend_in = '0;
    logic [1:0]  zc_in = '0;
    logic [1:0]  irq;

    int n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    bit done = 0;

    scc_regaccess dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr),
        .chan_sel(chan_sel), .wdata(wdata), .rdata(rdata),
        .rr0_stat(rr0_stat), .rr1_stat(rr1_stat), .vec_in(vec_in),
        .ipend_in(ipend_in), .zc_in(zc_in), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    // behavioural reference model
    int         m_st = 0;          // 0 idle, 1 reading, 2 writing
    int         m_ch = 0;
    logic [3:0] m_addr = '0;
    logic [7:0] m_snap = '0;
    logic [3:0] m_ptr [2];
    logic [7:0] m_w   [2][16];
    logic [7:0] m_p   [2];
    bit         m_pend[2];
    bit         m_zq  [2];

    task automatic m_write(int ch, logic [3:0] a, logic [7:0] d, ref bit clr [2]);
        if (a == 4'd0) begin
            m_ptr[ch] = d[3:0];
            if (d[6:4] == 3'b010) clr[ch] = 1;
            if (d[6:4] == 3'b011) begin
                clr[ch] = 1;
                m_p[ch] = 8'h00;
                for (int i = 0; i < 16; i++) m_w[ch][i] = 8'h00;
            end
        end else if (a == 4'd7 && m_w[ch][15][0]) m_p[ch] = d;
        else m_w[ch][a] = d;
    endtask

    function automatic logic [7:0] exp_rdata();
        bit e;
        if (m_st != 1) return 8'h00;
        e = m_p[m_ch][6];
        case (m_addr)
            4'd0: return m_snap;
            4'd1: return rr1_stat[m_ch*8 +: 8];
            4'd2: return vec_in;
            4'd3: return ipend_in;
            4'd4: return e ? m_w[m_ch][4] : m_snap;
            4'd5: return e ? m_w[m_ch][5] : m_snap;
            4'd9: return e ? m_w[m_ch][3] : m_snap;
            4'd11: return e ? m_w[m_ch][10] : m_snap;
            4'd14: return e ? m_p[m_ch] : m_snap;
            4'd12, 4'd13, 4'd15: return m_w[m_ch][m_addr];
            default: return m_snap;
        endcase
    endfunction

    always @(posedge clk) begin
        bit clr [2];
        clr[0] = 0; clr[1] = 0;
        if (!rst_n) begin
            m_st = 0; m_ch = 0; m_addr = '0; m_snap = '0;
            for (int c = 0; c < 2; c++) begin
                m_ptr[c] = '0; m_p[c] = '0; m_pend[c] = 0; m_zq[c] = 0;
                for (int i = 0; i < 16; i++) m_w[c][i] = '0;
            end
        end else begin
            case (m_st)
                0: if (cs && rd) begin
                       m_st = 1; m_ch = int'(chan_sel); m_addr = m_ptr[m_ch];
                       m_snap = rr0_stat[m_ch*8 +: 8];
                   end else if (cs && wr) begin
                       m_st = 2; m_ch = int'(chan_sel); m_addr = m_ptr[m_ch];
                       m_write(m_ch, m_addr, wdata, clr);
                   end
                1: if (!(cs && rd)) begin
                       if (m_addr != 0) m_ptr[m_ch] = '0;
                       m_st = 0;
                   end
                default: if (!(cs && wr)) begin
                       if (m_addr != 0) m_ptr[m_ch] = '0;
                       m_st = 0;
                   end
            endcase
            for (int c = 0; c < 2; c++) begin
                if (zc_in[c] && !m_zq[c]) m_pend[c] = 1;
                else if (clr[c]) m_pend[c] = 0;
                m_zq[c] = zc_in[c];
            end
        end
        #(CLK_P/4);
        if (!done) begin
            logic [7:0] er;
            logic [1:0] ei;
            er = exp_rdata();
            ei = {m_pend[1] && m_w[1][15][1], m_pend[0] && m_w[0][15][1]};
            n_chk++;
            if (rdata !== er) begin
                n_fail++;
                $display("FAIL %s (R12/model) rdata got %h exp %h", cur_req, rdata, er);
            end
            n_chk++;
            if (irq !== ei) begin
                n_fail++;
                $display("FAIL %s (R9/model) irq got %b exp %b", cur_req, irq, ei);
            end
        end
    end

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic bus_wr(int ch, logic [7:0] d);
        @(negedge clk); cs = 1; wr = 1; chan_sel = 1'(ch); wdata = d;
        @(negedge clk); cs = 0; wr = 0;
        @(negedge clk);
    endtask

    task automatic wreg(int ch, logic [3:0] a, logic [7:0] d);
        if (a != 0) bus_wr(ch, {4'h0, a});
        bus_wr(ch, d);
    endtask

    task automatic rreg(int ch, logic [3:0] a, output logic [7:0] v);
        if (a != 0) bus_wr(ch, {4'h0, a});
        @(negedge clk); cs = 1; rd = 1; chan_sel = 1'(ch);
        @(negedge clk); v = rdata;
        cs = 0; rd = 0;
        @(negedge clk);
    endtask

    task automatic zc_pulse(int ch);
        @(negedge clk); zc_in[ch] = 1;
        @(negedge clk); zc_in[ch] = 0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        rr0_stat = 16'h5A81; rr1_stat = 16'h2211;
        vec_in = 8'h9C; ipend_in = 8'h06;
        repeat (4) @(negedge clk);
        cur_req = "R1";
        chk("R1 rdata idle after reset", rdata, 8'h00);
        chk("R1 irq after reset", {6'h0, irq}, 8'h00);
        rst_n = 1;
        @(negedge clk);
        rreg(0, 4'd15, v); chk("R1 reg15 ch0 after reset", v, 8'h00);
        rreg(1, 4'd12, v); chk("R1 reg12 ch1 after reset", v, 8'h00);

        cur_req = "R8";
        wreg(0, 4'd12, 8'h5A); wreg(1, 4'd13, 8'hC3); wreg(1, 4'd15, 8'h80);
        rreg(0, 4'd12, v); chk("R8 ch0 reg12", v, 8'h5A);
        rreg(1, 4'd13, v); chk("R8 ch1 reg13", v, 8'hC3);
        rreg(1, 4'd15, v); chk("R8 ch1 reg15", v, 8'h80);

        cur_req = "R2";
        rreg(0, 4'd12, v);
        rreg(0, 4'd0, v); chk("R2 pointer back to 0 after access", v, 8'h81);
        bus_wr(1, 8'h0D);
        rreg(1, 4'd0, v); chk("R2 pointer selects reg13", v, 8'hC3);

        cur_req = "R7";
        rreg(0, 4'd2, v); chk("R7 vec ch0", v, 8'h9C);
        rreg(1, 4'd2, v); chk("R7 vec ch1", v, 8'h9C);
        rreg(1, 4'd3, v); chk("R7 ipend ch1", v, 8'h06);
        rreg(0, 4'd1, v); chk("R7 rr1 ch0", v, 8'h11);
        rreg(1, 4'd1, v); chk("R7 rr1 ch1", v, 8'h22);

        cur_req = "R3";
        wreg(0, 4'd4, 8'h21); wreg(0, 4'd5, 8'h22);
        wreg(0, 4'd3, 8'h23); wreg(0, 4'd10, 8'h24);
        wreg(0, 4'd7, 8'h11);
        rreg(0, 4'd14, v); chk("R3 steer clear leaves alternate at 0", v, 8'h81);
        wreg(0, 4'd15, 8'h01);
        wreg(0, 4'd7, 8'h40);
        cur_req = "R4";
        rreg(0, 4'd14, v); chk("R4 addr14 alternate", v, 8'h40);
        rreg(0, 4'd4, v);  chk("R4 addr4 reg4", v, 8'h21);
        rreg(0, 4'd5, v);  chk("R4 addr5 reg5", v, 8'h22);
        rreg(0, 4'd9, v);  chk("R4 addr9 reg3", v, 8'h23);
        rreg(0, 4'd11, v); chk("R4 addr11 reg10", v, 8'h24);
        cur_req = "R3";
        wreg(0, 4'd12, 8'h5A);
        wreg(0, 4'd7, 8'h44);
        rreg(0, 4'd14, v); chk("R3 steering sticky", v, 8'h44);
        wreg(0, 4'd15, 8'h00);
        wreg(0, 4'd7, 8'h55);
        rreg(0, 4'd14, v); chk("R3 steer cleared keeps alternate", v, 8'h44);

        cur_req = "R5";
        wreg(0, 4'd15, 8'h01); wreg(0, 4'd7, 8'h00); wreg(0, 4'd15, 8'h00);
        rreg(0, 4'd4, v);  chk("R5 addr4 alias", v, 8'h81);
        rreg(0, 4'd9, v);  chk("R5 addr9 alias", v, 8'h81);
        rreg(0, 4'd14, v); chk("R5 addr14 alias", v, 8'h81);
        rreg(0, 4'd7, v);  chk("R5 addr7 alias", v, 8'h81);
        rreg(0, 4'd10, v); chk("R5 addr10 alias", v, 8'h81);

        cur_req = "R6";
        rr0_stat[7:0] = 8'hA5;
        @(negedge clk); cs = 1; rd = 1; chan_sel = 1'b0;
        @(negedge clk); rr0_stat[7:0] = 8'h3C;
        repeat (3) @(negedge clk);
        chk("R6 frozen during read", rdata, 8'hA5);
        cs = 0; rd = 0;
        @(negedge clk);
        chk("R12 rdata zero after read", rdata, 8'h00);
        rreg(0, 4'd0, v); chk("R6 new read sees new status", v, 8'h3C);

        cur_req = "R9";
        wreg(0, 4'd15, 8'h02);
        zc_pulse(0);
        chk("R9 irq raised", {6'h0, irq}, 8'h01);
        cur_req = "R10";
        bus_wr(0, 8'h20);
        chk("R10 irq cleared", {6'h0, irq}, 8'h00);
        cur_req = "R9";
        wreg(0, 4'd15, 8'h00);
        zc_pulse(0);
        chk("R9 disabled no irq", {6'h0, irq}, 8'h00);
        wreg(0, 4'd15, 8'h02);
        chk("R9 latent pending exposed", {6'h0, irq}, 8'h01);
        bus_wr(0, 8'h20);

        cur_req = "R11";
        wreg(1, 4'd12, 8'h77); wreg(1, 4'd15, 8'h02);
        zc_pulse(1);
        chk("R11 ch1 irq before reset", {6'h0, irq}, 8'h02);
        bus_wr(1, 8'h30);
        chk("R11 ch1 irq after channel reset", {6'h0, irq}, 8'h00);
        rreg(1, 4'd12, v); chk("R11 ch1 reg12 cleared", v, 8'h00);
        rreg(0, 4'd12, v); chk("R11 ch0 reg12 untouched", v, 8'h5A);

        cur_req = "R1";
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk); rst_n = 1;
        @(negedge clk);
        rreg(0, 4'd12, v); chk("R1 reg12 after second reset", v, 8'h00);
        rreg(0, 4'd15, v); chk("R1 reg15 after second reset", v, 8'h00);

        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule